// File: doc/BRIEF.md
# Lockable Watchdog with Shared Prescaler

This block combines a free-running 14-bit prescaler with a 3-bit watchdog counter that is driven from one of the prescaler's stages. The prescaler advances on single-cycle enable strobes from one of two tick sources, a fast system tick or a slow subsystem tick. It starts counting as soon as reset is released. The watchdog counter advances once for each rising edge of the prescaler stage it has selected. When the counter overflows, the block sends a one-cycle reset request to the system.

Software works with the block over a small synchronous register bus. A timer control register picks the tick source and can restart the prescaler. A watchdog control register sets the timeout stage and the operating mode. The watchdog has a switchable mode, in which it can be turned on and off, and a locked mode, which stays on until the next system reset. Reading the clear register returns the counter and zeroes it, and this is how software services the watchdog.

Top module: `wdp_top`

## Requirements
- R1: The 14-bit prescaler is zero after reset and then counts one step per selected tick strobe, with no software action needed. It does not change on cycles without a selected tick.
- R2: Timer control (address 0) bit 0 selects the tick source: 0 selects `sys_tick` and 1 selects `sub_tick`. A read of address 0 returns this bit in bit 0 and zeros in the other bits.
- R3: Writing address 0 with bit 1 set restarts the prescaler at zero, but only while the watchdog is inactive. While the watchdog is active, the restart request is ignored.
- R4: Watchdog control (address 1) bits [1:0] select the stage that clocks the watchdog counter. Value 0 selects Q8 (prescaler bit 7), value 1 selects Q11 (bit 10), and values 2 and 3 select Q14 (bit 13). The counter advances by one on each rising edge of the selected stage.
- R5: When the counter is at 7 and another edge arrives, it wraps to 0. In the same step, `wd_reset` goes high for exactly one clock.
- R6: A read of address 2 returns the counter value in bits [2:0] and clears the counter to zero.
- R7: Address 1 bit 2 enables the watchdog in switchable mode. While the watchdog is neither enabled nor locked, the counter stays at 0 and no reset request is raised.
- R8: Writing address 1 with bit 3 set enters locked mode, and the watchdog becomes active. From then until reset, writes to address 1 are ignored. A read of address 1 returns {lock, enable, stage[1:0]} in bits [3:0].
- R9: The synchronous active-high `rst` clears the prescaler, the counter, the mode, the lock, the tick select and `wd_reset`.
- R10: Read data is registered and valid in the cycle after `rd_en`. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| sys_tick | input | 1 | Fast tick strobe for the prescaler |
| sub_tick | input | 1 | Slow tick strobe for the prescaler |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| wd_reset | output | 1 | One-cycle system reset request |

## Verification
The counter is driven with exact tick counts placed one tick before and exactly on the first rising edge of each stage. The same stages are also driven across several later edges and through a full overflow. Together these patterns separate the three stage choices from one another and reveal any off-by-one in edge detection or in the wrap point. Directed sequences then repeat a restart or a mode change while the watchdog is active, and read the counter back to show whether the prescaler or the mode actually moved. A tick on the unselected source must leave the count unchanged.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_TCTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_WCTL = 2'd1;
  localparam logic [ADDR_W-1:0] A_WCLR = 2'd2;

  typedef enum logic [1:0] {
    STG_LO  = 2'd0,
    STG_MID = 2'd1,
    STG_HI  = 2'd2,
    STG_HI2 = 2'd3
  } stage_e;

  typedef struct packed {
    logic   lock;
    logic   en;
    stage_e stage;
  } wctl_t;
endpackage

// File: rtl/wdp_prescaler.sv
module wdp_prescaler #(
  parameter int PRE_W   = 14,
  parameter int TAP_LO  = 8,
  parameter int TAP_MID = 11,
  parameter int TAP_HI  = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sys_tick,
  input  logic            sub_tick,
  input  logic            clk_sel,
  input  logic            restart,
  input  wdp_pkg::stage_e stage,
  output logic            tap_rise
);
  localparam int NTAP = 3;

  function automatic int tap_bit(input int i);
    case (i)
      0:       tap_bit = TAP_LO - 1;
      1:       tap_bit = TAP_MID - 1;
      default: tap_bit = TAP_HI - 1;
    endcase
  endfunction

  logic [PRE_W-1:0] count;
  logic [NTAP-1:0]  taps;
  logic             step;
  logic             tap_now;
  logic             tap_prev;
  logic [1:0]       idx;

  assign step = clk_sel ? sub_tick : sys_tick;

  always_ff @(posedge clk) begin
    if (rst || restart) count <= '0;
    else if (step)      count <= count + 1'b1;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign taps[i] = count[tap_bit(i)];
  end

  assign idx     = (stage == wdp_pkg::STG_HI2) ? 2'd2 : stage;
  assign tap_now = taps[idx];

  always_ff @(posedge clk) begin
    if (rst) tap_prev <= 1'b0;
    else     tap_prev <= tap_now;
  end

  assign tap_rise = tap_now && !tap_prev;

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(count)); // R1
endmodule

// File: rtl/wdp_wdog.sv
module wdp_wdog #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_rise,
  input  logic             ctl_wr,
  input  wdp_pkg::wctl_t   ctl_in,
  input  logic             clr,
  output wdp_pkg::wctl_t   ctl,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             wd_reset
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    ctl <= '0;
    else if (ctl_wr && !ctl.lock) ctl <= ctl_in;
  end

  assign active = ctl.en || ctl.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wd_reset <= 1'b0;
    end else begin
      wd_reset <= active && !clr && tap_rise && (cnt == CNT_MAX);
      if (!active || clr) cnt <= '0;
      else if (tap_rise)  cnt <= cnt + 1'b1;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wd_reset |=> !wd_reset); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctl.lock |=> (ctl.lock && $stable(ctl))); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!active && $past(!active)) |-> (cnt == '0)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1))); // R4
endmodule

// File: rtl/wdp_regs.sv
module wdp_regs #(
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [wdp_pkg::ADDR_W-1:0]  addr,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  logic [wdp_pkg::DATA_W-1:0]  wr_data,
  input  wdp_pkg::wctl_t              ctl,
  input  logic                        active,
  input  logic [CNT_W-1:0]            cnt,
  output logic                        clk_sel,
  output logic                        restart,
  output logic                        ctl_wr,
  output wdp_pkg::wctl_t              ctl_in,
  output logic                        clr,
  output logic [wdp_pkg::DATA_W-1:0]  rd_data
);
  import wdp_pkg::*;

  logic tctl_wr;

  assign tctl_wr = wr_en && (addr == A_TCTL);
  assign restart = tctl_wr && wr_data[1] && !active;
  assign ctl_wr  = wr_en && (addr == A_WCTL);
  assign ctl_in  = wctl_t'(wr_data[3:0]);
  assign clr     = rd_en && (addr == A_WCLR);

  always_ff @(posedge clk) begin
    if (rst)          clk_sel <= 1'b0;
    else if (tctl_wr) clk_sel <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        A_TCTL:  rd_data <= DATA_W'(clk_sel);
        A_WCTL:  rd_data <= DATA_W'(ctl);
        A_WCLR:  rd_data <= DATA_W'(cnt);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdp_top.sv
module wdp_top #(
  parameter int PRE_W   = 14,
  parameter int TAP_LO  = 8,
  parameter int TAP_MID = 11,
  parameter int TAP_HI  = 14,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sys_tick,
  input  logic       sub_tick,
  input  logic [1:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wd_reset
);
  wdp_pkg::wctl_t   ctl;
  wdp_pkg::wctl_t   ctl_in;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             clk_sel;
  logic             restart;
  logic             ctl_wr;
  logic             clr;
  logic             tap_rise;

  wdp_prescaler #(
    .PRE_W(PRE_W), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)
  ) u_pre (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .sub_tick(sub_tick),
    .clk_sel(clk_sel), .restart(restart), .stage(ctl.stage),
    .tap_rise(tap_rise)
  );

  wdp_wdog #(.CNT_W(CNT_W)) u_wd (
    .clk(clk), .rst(rst), .tap_rise(tap_rise), .ctl_wr(ctl_wr),
    .ctl_in(ctl_in), .clr(clr), .ctl(ctl), .active(active),
    .cnt(cnt), .wd_reset(wd_reset)
  );

  wdp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .ctl(ctl), .active(active), .cnt(cnt),
    .clk_sel(clk_sel), .restart(restart), .ctl_wr(ctl_wr),
    .ctl_in(ctl_in), .clr(clr), .rd_data(rd_data)
  );
endmodule

// File: tb/wdp_top_tb.sv
module wdp_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wd_reset;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int wide = 0;
  logic prev_rst_out = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  wdp_top u_dut (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .sub_tick(sub_tick),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wd_reset(wd_reset)
  );

  always @(posedge clk) begin
    if (wd_reset) pulses <= pulses + 1;
    if (wd_reset && prev_rst_out) wide <= wide + 1;
    prev_rst_out <= wd_reset;
  end

  // {stage[1:0], ticks[15:0], exp_cnt[2:0], exp_pulses[0]}
  localparam logic [21:0] VEC [11] = '{
    {2'd0, 16'd127,   3'd0, 1'b0},
    {2'd0, 16'd128,   3'd1, 1'b0},
    {2'd0, 16'd384,   3'd2, 1'b0},
    {2'd0, 16'd1664,  3'd7, 1'b0},
    {2'd0, 16'd1920,  3'd0, 1'b1},
    {2'd1, 16'd1023,  3'd0, 1'b0},
    {2'd1, 16'd1024,  3'd1, 1'b0},
    {2'd1, 16'd3072,  3'd2, 1'b0},
    {2'd1, 16'd15360, 3'd0, 1'b1},
    {2'd2, 16'd8191,  3'd0, 1'b0},
    {2'd3, 16'd8192,  3'd1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = int'(rd_data);
  endtask

  task automatic tick(input bit sub, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sub) sub_tick = 1'b1; else sys_tick = 1'b1;
    end
    @(negedge clk); sys_tick = 1'b0; sub_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 wd_reset after reset", int'(wd_reset), 0);
    rd(2'd1, v); check("R9 wctl after reset", v, 0);
    rd(2'd2, v); check("R9 counter after reset", v, 0);
    rd(2'd0, v); check("R9 tctl after reset", v, 0);

    // R1 prescaler runs from reset without restart
    wr(2'd1, 8'h04);
    tick(1'b0, 128);
    rd(2'd2, v); check("R1 auto-start count", v, 1);

    // R3 restart ignored while active
    tick(1'b0, 100);
    wr(2'd0, 8'h02);
    tick(1'b0, 156);
    rd(2'd2, v); check("R3 restart ignored while active", v, 1);

    // vector table: R4 R5 R6
    for (int k = 0; k < 11; k++) begin
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h04 | 8'(VEC[k][21:20]));
      p0 = pulses;
      tick(1'b0, int'(VEC[k][19:4]));
      rd(2'd2, v); check("R4 R5 table count", v, int'(VEC[k][3:1]));
      check("R5 table reset pulses", pulses - p0, int'(VEC[k][0]));
    end
    check("R5 pulse width one clock", wide, 0);

    // R6 read returns then clears
    wr(2'd1, 8'h00); wr(2'd0, 8'h02); wr(2'd1, 8'h04);
    tick(1'b0, 640);
    rd(2'd2, v); check("R6 read returns count", v, 3);
    rd(2'd2, v); check("R6 read cleared count", v, 0);

    // R7 disable in switchable mode
    tick(1'b0, 256);
    wr(2'd1, 8'h00);
    p0 = pulses;
    tick(1'b0, 3000);
    rd(2'd2, v); check("R7 disabled counter held", v, 0);
    check("R7 disabled no reset", pulses - p0, 0);

    // R2 tick source select
    wr(2'd0, 8'h03);
    rd(2'd0, v); check("R2 tctl readback", v, 1);
    wr(2'd1, 8'h04);
    tick(1'b0, 500);
    rd(2'd2, v); check("R2 unselected tick ignored", v, 0);
    tick(1'b1, 128);
    rd(2'd2, v); check("R2 selected sub tick counts", v, 1);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);

    // R8 lock
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h08);
    rd(2'd1, v); check("R8 lock readback", v, 8'h08);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R8 write ignored when locked", v, 8'h08);
    tick(1'b0, 128);
    rd(2'd2, v); check("R8 locked counter runs", v, 1);
    wr(2'd0, 8'h02);
    tick(1'b0, 130);
    rd(2'd2, v); check("R3 restart ignored when locked", v, 0);

    // R9 reset leaves lock
    do_reset();
    rd(2'd1, v); check("R9 lock cleared by reset", v, 0);
    wr(2'd1, 8'h05);
    rd(2'd1, v); check("R8 writable after reset", v, 8'h05);

    // R10 unmapped address
    rd(2'd3, v); check("R10 address 3 reads zero", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule